// File: doc/BRIEF.md
# Split-Section Binary Ripple Counter

This block is a four-bit binary counter built as two sections that share nothing but a reset. The low section is one toggle stage with its own count clock. The high section is a chain of three toggle stages, each clocked by the bit below it, with a second count clock of its own. Every stage changes state on the falling edge of its clock, so the bits settle one after another rather than together. Any decode of the outputs can therefore show short false codes while a carry ripples through.

Nothing inside the block connects the low section's output to the high section. The surrounding logic picks the mode by how it wires the two clocks. If `q[0]` drives `cnt1_n` and the pulses go to `cnt0_n`, the block is a divide-by-16 counter. If the pulses go to `cnt1_n` alone, the high section is a divide-by-8 counter, and the low stage is free for a separate divide-by-2 job.

Clearing is asynchronous and needs two inputs. All four stages are cleared only while both reset inputs are high. The clear overrides both count clocks.

Top module: `split_ripple_counter`

## Requirements
- R1: While `clr_a` and `clr_b` are both high, `q` is 0000 at once, with no clock edge needed. This holds even in the middle of a count.
- R2: With only one of `clr_a` or `clr_b` high, nothing is cleared, and both sections keep counting.
- R3: While the clear is held, falling edges on either count clock leave `q` at zero. After release, the first falling edge counts up from zero.
- R4: `q[0]` toggles on each high-to-low transition of `cnt0_n`. A rising edge of `cnt0_n` leaves `q` unchanged.
- R5: `q[1]` toggles on each high-to-low transition of `cnt1_n`. A rising edge of `cnt1_n` leaves `q` unchanged.
- R6: `q[2]` toggles on each falling edge of `q[1]`, and `q[3]` toggles on each falling edge of `q[2]`. As a result, `q[3:1]` counts in binary (`q[1]` least significant) once per falling edge of `cnt1_n`, and wraps from 7 to 0.
- R7: The sections are independent. Edges on `cnt0_n` never change `q[3:1]`, and edges on `cnt1_n` never change `q[0]`.
- R8: With `cnt1_n` tied externally to `q[0]`, `q` (`q[0]` least significant) equals the number of falling edges on `cnt0_n` since the clear, modulo 16. It wraps from 15 to 0.
- R9: If the clear rises in the same instant as a falling edge of `cnt0_n`, the clear wins, and `q` reads 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cnt0_n | input | 1 | Count clock of the divide-by-2 section, active on its falling edge |
| cnt1_n | input | 1 | Count clock of the divide-by-8 section, active on its falling edge |
| clr_a | input | 1 | First clear input; clears only together with `clr_b` |
| clr_b | input | 1 | Second clear input; clears only together with `clr_a` |
| q | output | 4 | Count bits; `q[0]` is the low section, `q[3:1]` the high section |

## Verification
Two functions can fall in the same instant: the asynchronous clear and a falling count edge. In the 16-count wiring, the clear also pulls `q[0]` low, which puts a falling edge on the high section's clock during the clear. The bench provokes both cases. It raises both clear inputs in the same step that drops `cnt0_n`, and it clears in the middle of a 16-count while `q[0]` is high. It judges each case by requiring `q` to read zero at once and to stay zero until release. It then requires the first falling edge after release to give exactly one.

// File: rtl/ripple_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the split ripple counter.
// Assumes: nothing beyond elaboration-time use.
package ripple_pkg;
    // Default number of toggle stages in the high (divide-by-8) section.
    parameter int unsigned DEF_HIGH_STAGES = 3;
    // Default number of inputs that must all be high to clear the counter.
    parameter int unsigned DEF_CLR_INPUTS = 2;
endpackage

// File: rtl/ripple_stage.sv
`timescale 1ns/1ps
// Module: ripple_stage
// One toggle flip-flop that flips on the falling edge of its clock.
// Assumes: clr is an asynchronous, active-high clear that dominates the clock.
module ripple_stage (
    input  logic clk_n,
    input  logic clr,
    output logic q
);
    // Toggle on a falling clock edge; clear at once when clr rises.
    always_ff @(negedge clk_n or posedge clr) begin
        if (clr) begin
            q <= 1'b0;
        end else begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/clear_gate.sv
`timescale 1ns/1ps
// Module: clear_gate
// Combines several clear requests with AND. The clear fires only when all
// of them are high.
// Assumes: the requests are glitch-free levels from the surrounding logic.
module clear_gate #(
    parameter int unsigned N_IN = ripple_pkg::DEF_CLR_INPUTS
) (
    input  logic [N_IN-1:0] req,
    output logic            clr
);
    // Reduce all requests to one clear level.
    always_comb begin
        clr = &req;
    end
endmodule

// File: rtl/ripple_section.sv
`timescale 1ns/1ps
// Module: ripple_section
// A chain of STAGES toggle stages. Stage 0 takes the section clock, and each
// later stage takes the falling edge of the stage below it. Bit 0 of q is
// the least significant bit of the section's count.
// Assumes: outputs settle one stage after another; consumers must not
// decode them as a clock.
module ripple_section #(
    parameter int unsigned STAGES = 1
) (
    input  logic              clk_n,
    input  logic              clr,
    output logic [STAGES-1:0] q
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] clk_chain;

    // The section clock feeds the first link of the chain.
    always_comb begin
        clk_chain[0] = clk_n;
    end

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        ripple_stage u_stage (
            .clk_n (clk_chain[i]),
            .clr   (clr),
            .q     (q[i])
        );
        // Each stage output clocks the next stage.
        always_comb begin
            clk_chain[i+1] = q[i];
        end
    end
endmodule

// File: rtl/split_ripple_counter.sv
`timescale 1ns/1ps
// Module: split_ripple_counter (top)
// A divide-by-2 section on cnt0_n and a divide-by-(2**HIGH_STAGES) section
// on cnt1_n. The two are not linked inside. Wiring q[0] to cnt1_n outside
// the block makes a full binary counter. Both sections clear asynchronously
// while clr_a and clr_b are both high.
// Assumes: the count clocks idle high and are glitch-free.
module split_ripple_counter #(
    parameter int unsigned HIGH_STAGES = ripple_pkg::DEF_HIGH_STAGES,
    parameter int unsigned NUM_BITS    = HIGH_STAGES + 1
) (
    input  logic                cnt0_n,
    input  logic                cnt1_n,
    input  logic                clr_a,
    input  logic                clr_b,
    output logic [NUM_BITS-1:0] q
);
    localparam int unsigned CLR_W = ripple_pkg::DEF_CLR_INPUTS;

    logic                   clr_all;
    logic                   low_q;
    logic [HIGH_STAGES-1:0] high_q;

    clear_gate #(.N_IN(CLR_W)) u_clr (
        .req ({clr_b, clr_a}),
        .clr (clr_all)
    );

    ripple_section #(.STAGES(1)) u_low (
        .clk_n (cnt0_n),
        .clr   (clr_all),
        .q     (low_q)
    );

    ripple_section #(.STAGES(HIGH_STAGES)) u_high (
        .clk_n (cnt1_n),
        .clr   (clr_all),
        .q     (high_q)
    );

    // Place the low bit below the high section's bits.
    always_comb begin
        q = {high_q, low_q};
    end
endmodule

// File: rtl/split_ripple_counter_chk.sv
`timescale 1ns/1ps
// Module: split_ripple_counter_chk
// Property checker bound to split_ripple_counter. Each toggle check uses a
// flag that records a clear since the previous edge of that clock, so a
// clear between two edges never counts as a missed toggle.
module split_ripple_counter_chk #(
    parameter int unsigned NUM_BITS = 4
) (
    input logic                cnt0_n,
    input logic                cnt1_n,
    input logic                clr_a,
    input logic                clr_b,
    input logic [NUM_BITS-1:0] q
);
    logic clr_all;
    logic armed   = 1'b0;
    logic cleared0 = 1'b1;
    logic cleared1 = 1'b1;

    assign clr_all = clr_a & clr_b;

    // Arm the checks once the first clear has been seen.
    always_ff @(posedge clr_all) armed <= 1'b1;

    // Note a clear since the last falling edge of cnt0_n.
    always_ff @(negedge cnt0_n or posedge clr_all) cleared0 <= clr_all;

    // Note a clear since the last falling edge of cnt1_n.
    always_ff @(negedge cnt1_n or posedge clr_all) cleared1 <= clr_all;

    // R1
    clear_zero_chk: assert property (@(posedge cnt0_n) disable iff (!armed)
        clr_all |-> q == '0);

    // R3
    clear_hold_chk: assert property (@(negedge cnt1_n) disable iff (!armed)
        clr_all |-> q[NUM_BITS-1:1] == '0);

    // R4
    low_toggle_chk: assert property (@(negedge cnt0_n) disable iff (!armed || clr_all)
        1'b1 |=> (cleared0 || q[0] != $past(q[0])));

    // R5
    high_first_toggle_chk: assert property (@(negedge cnt1_n) disable iff (!armed || clr_all)
        1'b1 |=> (cleared1 || q[1] != $past(q[1])));

    for (genvar i = 2; i < NUM_BITS; i++) begin : g_chain
        logic cleared_i = 1'b1;
        // Note a clear since the last falling edge of the lower bit.
        always_ff @(negedge q[i-1] or posedge clr_all) cleared_i <= clr_all;
        // R6
        chain_toggle_chk: assert property (@(negedge q[i-1]) disable iff (!armed || clr_all)
            1'b1 |=> (cleared_i || q[i] != $past(q[i])));
    end
endmodule

bind split_ripple_counter split_ripple_counter_chk #(.NUM_BITS(NUM_BITS)) u_chk (
    .cnt0_n (cnt0_n),
    .cnt1_n (cnt1_n),
    .clr_a  (clr_a),
    .clr_b  (clr_b),
    .q      (q)
);

// File: tb/tb_split_ripple_counter.sv
`timescale 1ns/1ps
// Bench: sweeps the split wiring and the 16-count wiring, with expected
// counts computed arithmetically. Inputs change at posedge clk; outputs are
// sampled at negedge clk.
module tb_split_ripple_counter;
    logic       clk = 1'b0;
    logic       c0 = 1'b1;
    logic       c1 = 1'b1;
    logic       mode16 = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       cnt1_n;
    logic [3:0] q;
    int         vectors = 0;
    int         fails = 0;
    bit         done = 1'b0;
    int         e0 = 0;
    int         ehi = 0;
    int         n16 = 0;

    always #2 clk = ~clk;

    assign cnt1_n = mode16 ? q[0] : c1;

    split_ripple_counter dut (
        .cnt0_n (c0),
        .cnt1_n (cnt1_n),
        .clr_a  (clr_a),
        .clr_b  (clr_b),
        .q      (q)
    );

    task automatic chk(input string req, input logic [3:0] exp);
        vectors++;
        if (q !== exp) begin
            fails++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    task automatic set_in(input logic n0, input logic n1, input logic ra, input logic rb);
        @(posedge clk);
        c0 = n0; c1 = n1; clr_a = ra; clr_b = rb;
        @(negedge clk);
    endtask

    function automatic logic [3:0] split_exp();
        return 4'((ehi % 8) * 2 + (e0 % 2));
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        // R1: clear with no clock edge
        set_in(1, 1, 1, 1);
        chk("R1 initial clear", 4'd0);
        set_in(1, 1, 0, 0);
        chk("R1 after release", 4'd0);

        // Split wiring sweep: R4, R5, R6, R7
        for (int k = 0; k < 10; k++) begin
            set_in(0, 1, 0, 0); e0++;
            chk("R4/R7 low fall", split_exp());
            set_in(1, 1, 0, 0);
            chk("R4 low rise", split_exp());
            set_in(1, 0, 0, 0); ehi++;
            chk("R5/R6/R7 high fall", split_exp());
            set_in(1, 1, 0, 0);
            chk("R5 high rise", split_exp());
        end

        // R2: one clear input alone does not clear
        set_in(1, 1, 1, 0);
        chk("R2 clr_a alone", split_exp());
        set_in(1, 0, 1, 0); ehi++;
        chk("R2 count with clr_a", split_exp());
        set_in(1, 1, 0, 1);
        chk("R2 clr_b alone", split_exp());
        set_in(0, 1, 0, 1); e0++;
        chk("R2 count with clr_b", split_exp());
        set_in(1, 1, 0, 0);

        // R1 / R3: clear mid-count, edges ignored while held
        set_in(1, 1, 1, 1); e0 = 0; ehi = 0;
        chk("R1 clear mid-count", 4'd0);
        for (int k = 0; k < 3; k++) begin
            set_in(0, 0, 1, 1);
            chk("R3 edges during clear", 4'd0);
            set_in(1, 1, 1, 1);
            chk("R3 held clear", 4'd0);
        end
        set_in(1, 1, 0, 0);
        chk("R3 release", 4'd0);
        set_in(1, 0, 0, 0); ehi++;
        chk("R3 first high edge after release", split_exp());
        set_in(0, 1, 0, 0); e0++;
        chk("R3 first low edge after release", split_exp());
        set_in(1, 1, 0, 0);

        // R8: 16-count wiring, switched while cleared
        set_in(1, 1, 1, 1);
        mode16 = 1'b1;
        set_in(1, 1, 0, 0);
        chk("R8 start", 4'd0);
        for (int k = 0; k < 40; k++) begin
            set_in(0, 1, 0, 0); n16++;
            chk((n16 % 16 == 0) ? "R8 wrap 15->0" : "R8 count", 4'(n16 % 16));
            set_in(1, 1, 0, 0);
            chk("R8 rise no change", 4'(n16 % 16));
        end

        // R1 / R3: clear in the middle of a 16-count, then resume
        for (int k = 0; k < 3; k++) begin
            set_in(0, 1, 0, 0); n16++;
            set_in(1, 1, 0, 0);
        end
        chk("R8 mid value 11", 4'd11);
        set_in(1, 1, 1, 1); n16 = 0;
        chk("R1 clear during 16-count", 4'd0);
        set_in(1, 1, 0, 0);
        for (int k = 0; k < 5; k++) begin
            set_in(0, 1, 0, 0); n16++;
            set_in(1, 1, 0, 0);
        end
        chk("R3/R8 resume to 5", 4'd5);

        // R9: clear and falling edge in the same instant
        set_in(0, 1, 1, 1); n16 = 0;
        chk("R9 clear beats edge", 4'd0);
        set_in(1, 1, 1, 1);
        chk("R9 held", 4'd0);
        set_in(1, 1, 0, 0);
        set_in(0, 1, 0, 0);
        chk("R9 first count after", 4'd1);
        set_in(1, 1, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule